// File: doc/BRIEF.md
# Chained-Network Path Tracker

This block is the per-stage routing decision of one switch in a bidirectional multistage network. In that network every switch of a stage is linked into a ring with its peers, so a packet that meets a broken output link can leave sideways to a neighbour switch instead of being lost. Requests may be merged inside switches on the way to memory. A reply must therefore climb back through exactly the switches its request passed through, or a merged entry waiting in some switch would never be split apart.

On the way towards memory the block picks an output from the destination tag. When the wanted link is broken, it sends the packet along the forward ring. The first time this happens in a stage, it marks a sideways-exit flag for that stage in the packet and records which switch the packet left from. It also rewrites the low source-tag bits so that the reply is steered to the switch the packet actually entered. If a packet comes back round the ring to the switch it first left from, it reports that the ring offers no way out. On the way back, the block reads the record. It walks the packet backwards round the ring until it reaches the recorded switch, puts the original source bits back, and then routes on the source tag. The decision is registered, so a result appears one clock after its input.

Top module: `cpt_path_tracker`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. All outputs carry the registered decision for that input. Reset clears `out_valid` and `out_disc`.
- R2: On the forward path (`in_dir`=0) with the wanted link sound, the packet leaves on port code 0 (upper) when destination bit d_i = `in_dst[N_LOG-1-i]` is 0, and on port code 1 (lower) when it is 1. Here i is `in_stage`. Source tag, flags and record pass unchanged. Link fault flags: bit 0 upper, bit 1 lower.
- R3: On the forward path with the wanted link faulty and flag bit `cind[i]` clear, the output port is code 2 (ring). `cind[i]` is set, and field L_i receives `my_id[N_LOG-2:i]`. Field L_i sits in the record at offset i*(N_LOG-1) - i*(i-1)/2 and is N_LOG-1-i bits wide.
- R4: When the forward path uses the ring, source bits `src[N_LOG-2-i:0]` are replaced by bits [N_LOG-2:i] of the target ID (`my_id` + 2^i) mod 2^(N_LOG-1).
- R5: When a forward packet needs the ring in a stage whose flag is already set, L_i and the flags keep their values. The source rewrite of R4 still happens.
- R6: A forward packet that arrived on the ring (`in_chain`=1), with `cind[i]` set and L_i equal to `my_id[N_LOG-2:i]`, raises `out_disc` and gets port code 3. The header is left unchanged.
- R7: In the last stage (i = N_LOG-1) a faulty wanted link gives `out_disc`=1 and port code 3. The ring is never chosen there.
- R8: On the return path (`in_dir`=1) with `cind[i]` clear, the port is s_i = `in_src[N_LOG-1-i]` (0 upper, 1 lower), and the source tag is unchanged.
- R9: On the return path with `cind[i]` set and `my_id[N_LOG-2:i]` different from L_i, the port is code 2. Source bits `src[N_LOG-2-i:0]` become bits [N_LOG-2:i] of (`my_id` - 2^i) mod 2^(N_LOG-1).
- R10: On the return path with `cind[i]` set and `my_id[N_LOG-2:i]` equal to L_i, source bits `src[N_LOG-2-i:0]` are restored from L_i. The port is then s_i of the restored tag.
- R11: The return path never alters the flags or the record and never raises `out_disc`. The forward path changes no record field other than L_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Header present this cycle |
| in_dir | input | 1 | 0 forward (towards memory), 1 return |
| in_chain | input | 1 | Packet entered through the ring input |
| in_stage | input | $clog2(N_LOG) | Stage index i of this switch |
| my_id | input | N_LOG-1 | Switch position within its stage |
| link_fault | input | 2 | Fault flags of the upper (bit 0) and lower (bit 1) link |
| in_dst | input | N_LOG | Destination tag, d_0 in the MSB |
| in_src | input | N_LOG | Source tag, s_0 in the MSB |
| in_cind | input | N_LOG-1 | Sideways-exit flags, bit i for stage i |
| in_lrec | input | N_LOG*(N_LOG-1)/2 | Packed exit-switch fields L_i |
| out_valid | output | 1 | Decision valid |
| out_port | output | 2 | 0 upper, 1 lower, 2 ring, 3 dropped |
| out_dst | output | N_LOG | Destination tag, passed on |
| out_src | output | N_LOG | Updated source tag |
| out_cind | output | N_LOG-1 | Updated flags |
| out_lrec | output | N_LOG*(N_LOG-1)/2 | Updated record |
| out_disc | output | 1 | Ring exhausted, no path |

## Verification
The hardest cases are those that depend on what happened to the packet at earlier switches. Examples are a packet returning round the ring to its first exit switch, or a reply arriving at a switch that is not its recorded origin. A lone switch cannot produce these by itself. The stimulus therefore builds the header as upstream switches would have left it, with the flag set, L_i filled and the ring-entry input raised. It then replays the reply of the faulty-link scenario hop by hop: first at the neighbour switch, which must send it back round the ring, then at the origin switch, which must restore the tag and deliver it to processor 0.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    typedef enum logic [1:0] {
        PORT_UP    = 2'd0,
        PORT_DN    = 2'd1,
        PORT_CHAIN = 2'd2,
        PORT_DROP  = 2'd3
    } port_e;

    // Bit offset of stage field L_i in the packed record
    function automatic int rec_off(input int n_log, input int i);
        return i * (n_log - 1) - (i * (i - 1)) / 2;
    endfunction

    function automatic int rec_width(input int n_log);
        return (n_log * (n_log - 1)) / 2;
    endfunction

endpackage

// File: rtl/cpt_fwd_route.sv
module cpt_fwd_route
    import cpt_pkg::*;
#(
    parameter  int N_LOG = 3,
    localparam int ID_W  = N_LOG - 1,
    localparam int REC_W = rec_width(N_LOG),
    localparam int SW    = (N_LOG > 2) ? $clog2(N_LOG) : 1
) (
    input  logic [SW-1:0]    stage,
    input  logic [ID_W-1:0]  my_id,
    input  logic             chain_in,
    input  logic [1:0]       link_fault,
    input  logic [N_LOG-1:0] dst,
    input  logic [N_LOG-1:0] src,
    input  logic [ID_W-1:0]  cind,
    input  logic [REC_W-1:0] lrec,
    output port_e            port,
    output logic [N_LOG-1:0] src_o,
    output logic [ID_W-1:0]  cind_o,
    output logic [REC_W-1:0] lrec_o,
    output logic             disc
);

    port_e            g_port [N_LOG];
    logic [N_LOG-1:0] g_src  [N_LOG];
    logic [ID_W-1:0]  g_cind [N_LOG];
    logic [REC_W-1:0] g_lrec [N_LOG];
    logic             g_disc [N_LOG];

    for (genvar i = 0; i < N_LOG - 1; i++) begin : g_stage
        localparam int LW  = ID_W - i;
        localparam int OFF = rec_off(N_LOG, i);

        logic [LW-1:0]    up_id, l_old;
        logic [ID_W-1:0]  tgt_id;
        logic             want_dn, blocked, loop_hit;
        port_e            port_c;
        logic [N_LOG-1:0] src_c;
        logic [ID_W-1:0]  cind_c;
        logic [REC_W-1:0] lrec_c;
        logic             disc_c;

        always_comb begin
            up_id    = my_id[ID_W-1:i];
            l_old    = lrec[OFF +: LW];
            tgt_id   = my_id + (ID_W'(1) << i);
            want_dn  = dst[N_LOG-1-i];
            blocked  = link_fault[want_dn];
            loop_hit = chain_in && cind[i] && (l_old == up_id);

            src_c  = src;
            cind_c = cind;
            lrec_c = lrec;
            disc_c = 1'b0;
            port_c = want_dn ? PORT_DN : PORT_UP;

            if (loop_hit) begin
                disc_c = 1'b1;
                port_c = PORT_DROP;
            end else if (blocked) begin
                port_c          = PORT_CHAIN;
                src_c[LW-1:0]   = tgt_id[ID_W-1:i];
                if (!cind[i]) begin
                    cind_c[i]          = 1'b1;
                    lrec_c[OFF +: LW]  = up_id;
                end
            end
        end

        assign g_port[i] = port_c;
        assign g_src[i]  = src_c;
        assign g_cind[i] = cind_c;
        assign g_lrec[i] = lrec_c;
        assign g_disc[i] = disc_c;
    end

    // Last stage: the ring wraps onto itself, so a fault means no path
    logic last_dn, last_blk;
    assign last_dn  = dst[0];
    assign last_blk = link_fault[last_dn];
    assign g_port[N_LOG-1] = last_blk ? PORT_DROP : (last_dn ? PORT_DN : PORT_UP);
    assign g_src[N_LOG-1]  = src;
    assign g_cind[N_LOG-1] = cind;
    assign g_lrec[N_LOG-1] = lrec;
    assign g_disc[N_LOG-1] = last_blk;

    int sel;
    always_comb begin
        sel    = (int'(stage) < N_LOG) ? int'(stage) : N_LOG - 1;
        port   = g_port[sel];
        src_o  = g_src[sel];
        cind_o = g_cind[sel];
        lrec_o = g_lrec[sel];
        disc   = g_disc[sel];
    end

endmodule

// File: rtl/cpt_ret_route.sv
module cpt_ret_route
    import cpt_pkg::*;
#(
    parameter  int N_LOG = 3,
    localparam int ID_W  = N_LOG - 1,
    localparam int REC_W = rec_width(N_LOG),
    localparam int SW    = (N_LOG > 2) ? $clog2(N_LOG) : 1
) (
    input  logic [SW-1:0]    stage,
    input  logic [ID_W-1:0]  my_id,
    input  logic [N_LOG-1:0] src,
    input  logic [ID_W-1:0]  cind,
    input  logic [REC_W-1:0] lrec,
    output port_e            port,
    output logic [N_LOG-1:0] src_o
);

    port_e            g_port [N_LOG];
    logic [N_LOG-1:0] g_src  [N_LOG];

    for (genvar i = 0; i < N_LOG - 1; i++) begin : g_stage
        localparam int LW  = ID_W - i;
        localparam int OFF = rec_off(N_LOG, i);

        logic [LW-1:0]    up_id, l_old;
        logic [ID_W-1:0]  prv_id;
        port_e            port_c;
        logic [N_LOG-1:0] src_c;

        always_comb begin
            up_id  = my_id[ID_W-1:i];
            l_old  = lrec[OFF +: LW];
            prv_id = my_id - (ID_W'(1) << i);
            src_c  = src;
            if (cind[i] && (l_old != up_id)) begin
                port_c        = PORT_CHAIN;
                src_c[LW-1:0] = prv_id[ID_W-1:i];
            end else begin
                if (cind[i]) begin
                    src_c[LW-1:0] = l_old;
                end
                port_c = src_c[N_LOG-1-i] ? PORT_DN : PORT_UP;
            end
        end

        assign g_port[i] = port_c;
        assign g_src[i]  = src_c;
    end

    assign g_port[N_LOG-1] = src[0] ? PORT_DN : PORT_UP;
    assign g_src[N_LOG-1]  = src;

    int sel;
    always_comb begin
        sel   = (int'(stage) < N_LOG) ? int'(stage) : N_LOG - 1;
        port  = g_port[sel];
        src_o = g_src[sel];
    end

endmodule

// File: rtl/cpt_path_tracker.sv
module cpt_path_tracker
    import cpt_pkg::*;
#(
    parameter  int N_LOG = 3,
    localparam int ID_W  = N_LOG - 1,
    localparam int REC_W = rec_width(N_LOG),
    localparam int SW    = (N_LOG > 2) ? $clog2(N_LOG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_dir,
    input  logic             in_chain,
    input  logic [SW-1:0]    in_stage,
    input  logic [ID_W-1:0]  my_id,
    input  logic [1:0]       link_fault,
    input  logic [N_LOG-1:0] in_dst,
    input  logic [N_LOG-1:0] in_src,
    input  logic [ID_W-1:0]  in_cind,
    input  logic [REC_W-1:0] in_lrec,
    output logic             out_valid,
    output logic [1:0]       out_port,
    output logic [N_LOG-1:0] out_dst,
    output logic [N_LOG-1:0] out_src,
    output logic [ID_W-1:0]  out_cind,
    output logic [REC_W-1:0] out_lrec,
    output logic             out_disc
);

    typedef struct packed {
        logic             vld;
        logic             disc;
        port_e            port;
        logic [N_LOG-1:0] dst;
        logic [N_LOG-1:0] src;
        logic [ID_W-1:0]  cind;
        logic [REC_W-1:0] lrec;
    } dec_t;

    port_e            fw_port, rt_port;
    logic [N_LOG-1:0] fw_src, rt_src;
    logic [ID_W-1:0]  fw_cind;
    logic [REC_W-1:0] fw_lrec;
    logic             fw_disc;
    dec_t             dec_d, dec_q;

    cpt_fwd_route #(.N_LOG(N_LOG)) u_fwd (
        .stage(in_stage), .my_id(my_id), .chain_in(in_chain),
        .link_fault(link_fault), .dst(in_dst), .src(in_src),
        .cind(in_cind), .lrec(in_lrec), .port(fw_port), .src_o(fw_src),
        .cind_o(fw_cind), .lrec_o(fw_lrec), .disc(fw_disc)
    );

    cpt_ret_route #(.N_LOG(N_LOG)) u_ret (
        .stage(in_stage), .my_id(my_id), .src(in_src), .cind(in_cind),
        .lrec(in_lrec), .port(rt_port), .src_o(rt_src)
    );

    always_comb begin
        dec_d.vld = in_valid;
        dec_d.dst = in_dst;
        if (!in_dir) begin
            dec_d.port = fw_port;
            dec_d.src  = fw_src;
            dec_d.cind = fw_cind;
            dec_d.lrec = fw_lrec;
            dec_d.disc = fw_disc;
        end else begin
            dec_d.port = rt_port;
            dec_d.src  = rt_src;
            dec_d.cind = in_cind;
            dec_d.lrec = in_lrec;
            dec_d.disc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid = dec_q.vld;
    assign out_port  = dec_q.port;
    assign out_dst   = dec_q.dst;
    assign out_src   = dec_q.src;
    assign out_cind  = dec_q.cind;
    assign out_lrec  = dec_q.lrec;
    assign out_disc  = dec_q.disc;

    assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_fwd_pass_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dir && !link_fault[0] && !link_fault[1] && !in_chain)
        |=> (out_src == $past(in_src) && out_cind == $past(in_cind)));

    assert_one_new_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dir) |=> $onehot0(out_cind ^ $past(in_cind)));

    assert_last_no_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dir && int'(in_stage) == N_LOG - 1)
        |=> (out_port != PORT_CHAIN));

    assert_ret_keep_rec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir)
        |=> (out_cind == $past(in_cind) && out_lrec == $past(in_lrec) && !out_disc));

    assert_drop_has_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == PORT_DROP) |-> out_disc);

endmodule

// File: tb/cpt_path_tracker_tb.sv
module cpt_path_tracker_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_dir, in_chain;
    logic [1:0] in_stage, my_id, link_fault;
    logic [2:0] in_dst, in_src;
    logic [1:0] in_cind;
    logic [2:0] in_lrec;
    logic       out_valid, out_disc;
    logic [1:0] out_port, out_cind;
    logic [2:0] out_dst, out_src, out_lrec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpt_path_tracker #(.N_LOG(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
        .in_chain(in_chain), .in_stage(in_stage), .my_id(my_id),
        .link_fault(link_fault), .in_dst(in_dst), .in_src(in_src),
        .in_cind(in_cind), .in_lrec(in_lrec), .out_valid(out_valid),
        .out_port(out_port), .out_dst(out_dst), .out_src(out_src),
        .out_cind(out_cind), .out_lrec(out_lrec), .out_disc(out_disc)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one header at a falling edge; the result is visible at the next one
    task automatic send(input logic dir, input logic chn, input logic [1:0] stg,
                        input logic [1:0] id, input logic [1:0] flt,
                        input logic [2:0] dst, input logic [2:0] src,
                        input logic [1:0] cind, input logic [2:0] lrec);
        in_valid = 1'b1; in_dir = dir; in_chain = chn; in_stage = stg;
        my_id = id; link_fault = flt; in_dst = dst; in_src = src;
        in_cind = cind; in_lrec = lrec;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_hdr(input string tag, input logic [1:0] port,
                              input logic [2:0] src, input logic [1:0] cind,
                              input logic [2:0] lrec, input logic disc);
        check({tag, " valid"}, 8'(out_valid), 8'd1);
        check({tag, " port"},  8'(out_port),  8'(port));
        check({tag, " src"},   8'(out_src),   8'(src));
        check({tag, " cind"},  8'(out_cind),  8'(cind));
        check({tag, " lrec"},  8'(out_lrec),  8'(lrec));
        check({tag, " disc"},  8'(out_disc),  8'(disc));
    endtask

    task automatic t_reset_and_latency();
        check("R1 reset valid", 8'(out_valid), 8'd0);
        check("R1 reset disc",  8'(out_disc),  8'd0);
        send(1'b0, 1'b0, 2'd0, 2'd0, 2'b00, 3'b000, 3'b000, 2'b00, 3'b000);
        check("R1 valid after one clock", 8'(out_valid), 8'd1);
        @(negedge clk);
        check("R1 idle gives no valid", 8'(out_valid), 8'd0);
    endtask

    task automatic t_fwd_clean();
        send(1'b0, 1'b0, 2'd0, 2'd0, 2'b00, 3'b000, 3'b011, 2'b00, 3'b000);
        expect_hdr("R2 stage0 d0=0", 2'd0, 3'b011, 2'b00, 3'b000, 1'b0);
        send(1'b0, 1'b0, 2'd0, 2'd0, 2'b00, 3'b100, 3'b000, 2'b00, 3'b000);
        expect_hdr("R2 stage0 d0=1", 2'd1, 3'b000, 2'b00, 3'b000, 1'b0);
        check("R2 dst passes", 8'(out_dst), 8'h4);
        send(1'b0, 1'b0, 2'd1, 2'd2, 2'b00, 3'b010, 3'b101, 2'b01, 3'b010);
        expect_hdr("R2 stage1 d1=1", 2'd1, 3'b101, 2'b01, 3'b010, 1'b0);
    endtask

    task automatic t_first_fault();
        // faulty upper link at stage 0 switch 0, PE0 to MM0
        send(1'b0, 1'b0, 2'd0, 2'd0, 2'b01, 3'b000, 3'b000, 2'b00, 3'b000);
        expect_hdr("R3 R4 stage0 sw0 ring", 2'd2, 3'b001, 2'b01, 3'b000, 1'b0);
        send(1'b0, 1'b0, 2'd0, 2'd2, 2'b01, 3'b000, 3'b110, 2'b00, 3'b000);
        expect_hdr("R3 R4 stage0 sw2 ring", 2'd2, 3'b111, 2'b01, 3'b010, 1'b0);
        // stage 1: L0 already present must survive (R11)
        send(1'b0, 1'b0, 2'd1, 2'd3, 2'b01, 3'b000, 3'b001, 2'b01, 3'b001);
        expect_hdr("R3 R4 R11 stage1 ring", 2'd2, 3'b000, 2'b11, 3'b101, 1'b0);
    endtask

    task automatic t_chained_in();
        send(1'b0, 1'b1, 2'd0, 2'd1, 2'b00, 3'b000, 3'b001, 2'b01, 3'b000);
        expect_hdr("R6 neighbour clean link", 2'd0, 3'b001, 2'b01, 3'b000, 1'b0);
        send(1'b0, 1'b1, 2'd0, 2'd1, 2'b01, 3'b000, 3'b001, 2'b01, 3'b000);
        expect_hdr("R5 second fault keeps L0", 2'd2, 3'b010, 2'b01, 3'b000, 1'b0);
        send(1'b0, 1'b1, 2'd0, 2'd0, 2'b01, 3'b000, 3'b000, 2'b01, 3'b000);
        expect_hdr("R6 loop back to origin", 2'd3, 3'b000, 2'b01, 3'b000, 1'b1);
    endtask

    task automatic t_last_stage();
        send(1'b0, 1'b0, 2'd2, 2'd0, 2'b10, 3'b001, 3'b000, 2'b00, 3'b000);
        expect_hdr("R7 last stage fault", 2'd3, 3'b000, 2'b00, 3'b000, 1'b1);
        send(1'b0, 1'b0, 2'd2, 2'd0, 2'b01, 3'b001, 3'b000, 2'b00, 3'b000);
        expect_hdr("R7 last stage other link", 2'd1, 3'b000, 2'b00, 3'b000, 1'b0);
    endtask

    task automatic t_return();
        send(1'b1, 1'b0, 2'd0, 2'd0, 2'b00, 3'b000, 3'b100, 2'b00, 3'b000);
        expect_hdr("R8 return s0=1", 2'd1, 3'b100, 2'b00, 3'b000, 1'b0);
        send(1'b1, 1'b0, 2'd2, 2'd0, 2'b00, 3'b000, 3'b001, 2'b00, 3'b000);
        expect_hdr("R8 return last s2=1", 2'd1, 3'b001, 2'b00, 3'b000, 1'b0);
        // reply of the faulty-link case, first at switch 1 then at switch 0
        send(1'b1, 1'b0, 2'd0, 2'd1, 2'b00, 3'b000, 3'b001, 2'b01, 3'b000);
        expect_hdr("R9 R11 reply back on ring", 2'd2, 3'b000, 2'b01, 3'b000, 1'b0);
        send(1'b1, 1'b1, 2'd0, 2'd0, 2'b00, 3'b000, 3'b000, 2'b01, 3'b000);
        expect_hdr("R10 reply to PE0", 2'd0, 3'b000, 2'b01, 3'b000, 1'b0);
        send(1'b1, 1'b0, 2'd0, 2'd0, 2'b00, 3'b000, 3'b101, 2'b01, 3'b000);
        expect_hdr("R10 restore source bits", 2'd1, 3'b100, 2'b01, 3'b000, 1'b0);
        send(1'b1, 1'b0, 2'd1, 2'd3, 2'b00, 3'b000, 3'b001, 2'b10, 3'b000);
        expect_hdr("R9 stage1 ring back", 2'd2, 3'b000, 2'b10, 3'b000, 1'b0);
        send(1'b1, 1'b0, 2'd1, 2'd1, 2'b00, 3'b000, 3'b010, 2'b10, 3'b000);
        expect_hdr("R10 stage1 at origin", 2'd1, 3'b010, 2'b10, 3'b000, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_dir = 1'b0; in_chain = 1'b0;
        in_stage = '0; my_id = '0; link_fault = '0; in_dst = '0;
        in_src = '0; in_cind = '0; in_lrec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_latency();
        t_fwd_clean();
        t_first_fault();
        t_chained_in();
        t_last_stage();
        t_return();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule